// File: doc/BRIEF.md
# Asynchronous Input Qualifier and Edge Detector

This block accepts a group of active-low control inputs that may change at any time relative to the core clock. Each input is resynchronised through two flops. All counting and decisions use the synchronised samples, never the raw pins. The inputs fall into two groups.

Level-type inputs produce a qualified active-high level once they have been seen asserted on enough consecutive samples. Edge-type inputs produce a single one-cycle event pulse. The pulse appears only when the input was negated long enough before it asserts and then stays asserted long enough. Activity that is too short, or that arrives too soon, is rejected rather than passed on. Each rejection sets a sticky per-input flag, which is cleared by writing 1 to the matching clear bit.

One level input can be overridden by a configuration bit. While that bit is set, the input reads as permanently satisfied, and its rejections are not flagged.

Top module: `async_input_qualifier`

## Requirements
- R1: While `rst_ni` is low, `edg_o` and `glitch_o` are all 0, and every `lvl_o` bit is 0 while `cfg_mask_i` is 0.
- R2: A level input `lvl_n_i[i]` (asserted = 0) held low for MIN_HI (default 2) consecutive clock edges raises `lvl_o[i]`. With the first low sample at edge k, `lvl_o[i]` is 1 after edge k+3. It stays 1 while the input stays low. With the first high sample at edge j, it returns to 0 after edge j+2.
- R3: A level input low for fewer than MIN_HI consecutive edges never raises `lvl_o[i]`, and it sets `glitch_o[i]`.
- R4: An edge input `edg_n_i[j]` (asserted = 0) that was high for at least MIN_LO (default 2) consecutive edges and then is low for MIN_HI consecutive edges produces `edg_o[j]` = 1. With the first low sample at edge k, the pulse is 1 only between edge k+3 and edge k+4.
- R5: Each qualified edge yields exactly one pulse of one cycle, however long the input stays low.
- R6: An edge input that goes low after fewer than MIN_LO high samples gives no pulse, and it sets `glitch_o[N_LVL+j]`.
- R7: An edge input low for fewer than MIN_HI consecutive edges after a valid arming gives no pulse, and it sets `glitch_o[N_LVL+j]`.
- R8: Each `glitch_o` bit (level input i at bit i, edge input j at bit N_LVL+j) stays set until the clock edge at which the same bit of `glitch_clr_i` is 1. If a set and a clear happen on the same edge, the set wins.
- R9: While `cfg_mask_i` is 1, `lvl_o[MASK_IDX]` (default 3) reads 1 whatever its input does, and `glitch_o[MASK_IDX]` is not set by that input. All other outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lvl_n_i | input | N_LVL | Level-type control inputs, active low |
| edg_n_i | input | N_EDG | Edge-type control inputs, active low |
| cfg_mask_i | input | 1 | Forces level input MASK_IDX to read as satisfied |
| glitch_clr_i | input | N_LVL+N_EDG | Write-1-to-clear for the rejection flags |
| lvl_o | output | N_LVL | Qualified levels, active high |
| edg_o | output | N_EDG | One-cycle edge event pulses |
| glitch_o | output | N_LVL+N_EDG | Sticky rejection flags |

## Verification
A bad run counter shows at the ports in one of three ways: `lvl_o` or `edg_o` rising on the wrong edge relative to the first low sample, a pulse wider than one cycle, or a second pulse from a single assertion. Each of these is visible within four clocks of the input change. A wrong arming state shows as a pulse after too short a negated gap, or as a missing pulse after exactly MIN_LO high samples. Flag errors persist until cleared, so they can be read at any later point.

// File: rtl/aiq_pkg.sv
package aiq_pkg;
  // width of a counter that must hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/aiq_sync.sv
module aiq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/aiq_level_qual.sv
module aiq_level_qual #(
  parameter int unsigned MIN_HI = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic lvl_o,
  output logic rej_o
);
  localparam int unsigned CW = aiq_pkg::cnt_w(MIN_HI);
  localparam logic [CW-1:0] HI_TOP = CW'(MIN_HI);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!s_i)             cnt_q <= '0;
    else if (cnt_q != HI_TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign lvl_o = (cnt_q == HI_TOP);
  // run ended before reaching the qualifying length
  assign rej_o = !s_i && (cnt_q != '0) && (cnt_q != HI_TOP);
endmodule

// File: rtl/aiq_edge_qual.sv
module aiq_edge_qual #(
  parameter int unsigned MIN_LO = 2,
  parameter int unsigned MIN_HI = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic pulse_o,
  output logic rej_o
);
  localparam int unsigned LW = aiq_pkg::cnt_w(MIN_LO);
  localparam int unsigned HW = aiq_pkg::cnt_w(MIN_HI);
  localparam logic [LW-1:0] LO_TOP  = LW'(MIN_LO);
  localparam logic [HW-1:0] HI_TOP  = HW'(MIN_HI);
  localparam logic [HW-1:0] HI_LAST = HW'(MIN_HI - 1);

  logic [LW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          cand_q;
  logic          pls_q;
  logic          armed_lo, armed_now, fire;

  assign armed_lo  = (lo_q == LO_TOP);
  // candidate status is decided at the rising sample and then held
  assign armed_now = (hi_q == '0) ? armed_lo : cand_q;
  assign fire      = s_i && armed_now && (hi_q == HI_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cand_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      pls_q <= fire;
      if (s_i) begin
        lo_q   <= '0;
        cand_q <= armed_now;
        if (hi_q != HI_TOP) hi_q <= hi_q + 1'b1;
      end else begin
        hi_q   <= '0;
        cand_q <= 1'b0;
        if (lo_q != LO_TOP) lo_q <= lo_q + 1'b1;
      end
    end
  end

  assign pulse_o = pls_q;
  assign rej_o   = s_i ? ((hi_q == '0) && !armed_lo)
                       : (cand_q && (hi_q != '0) && (hi_q != HI_TOP));
endmodule

// File: rtl/aiq_flags.sv
module aiq_flags #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flg_o
);
  logic [W-1:0] flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr_i) | set_i;
  end

  assign flg_o = flg_q;
endmodule

// File: rtl/async_input_qualifier.sv
module async_input_qualifier #(
  parameter int unsigned N_LVL    = 4,
  parameter int unsigned N_EDG    = 4,
  parameter int unsigned MIN_LO   = 2,
  parameter int unsigned MIN_HI   = 2,
  parameter int unsigned MASK_IDX = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_LVL-1:0]       lvl_n_i,
  input  logic [N_EDG-1:0]       edg_n_i,
  input  logic                   cfg_mask_i,
  input  logic [N_LVL+N_EDG-1:0] glitch_clr_i,
  output logic [N_LVL-1:0]       lvl_o,
  output logic [N_EDG-1:0]       edg_o,
  output logic [N_LVL+N_EDG-1:0] glitch_o
);
  localparam int unsigned NG = N_LVL + N_EDG;

  logic [NG-1:0]    s;
  logic [NG-1:0]    rej;
  logic [N_LVL-1:0] lq, lrej;

  // invert to active-high before synchronising; reset value reads as negated
  aiq_sync #(.W(NG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({~edg_n_i, ~lvl_n_i}),
    .q_o    (s)
  );

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    aiq_level_qual #(.MIN_HI(MIN_HI)) u_lq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .s_i    (s[i]),
      .lvl_o  (lq[i]),
      .rej_o  (lrej[i])
    );
    if (i == MASK_IDX) begin : g_mask
      assign lvl_o[i] = lq[i] | cfg_mask_i;
      assign rej[i]   = lrej[i] & ~cfg_mask_i;
    end else begin : g_plain
      assign lvl_o[i] = lq[i];
      assign rej[i]   = lrej[i];
    end
  end

  for (genvar j = 0; j < N_EDG; j++) begin : g_edg
    aiq_edge_qual #(.MIN_LO(MIN_LO), .MIN_HI(MIN_HI)) u_eq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .s_i     (s[N_LVL+j]),
      .pulse_o (edg_o[j]),
      .rej_o   (rej[N_LVL+j])
    );
  end

  aiq_flags #(.W(NG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rej),
    .clr_i  (glitch_clr_i),
    .flg_o  (glitch_o)
  );
endmodule

// File: rtl/aiq_checker.sv
module aiq_checker #(
  parameter int unsigned N_LVL    = 4,
  parameter int unsigned N_EDG    = 4,
  parameter int unsigned MASK_IDX = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_LVL-1:0]       lvl_n_i,
  input logic [N_EDG-1:0]       edg_n_i,
  input logic                   cfg_mask_i,
  input logic [N_LVL+N_EDG-1:0] glitch_clr_i,
  input logic [N_LVL-1:0]       lvl_o,
  input logic [N_EDG-1:0]       edg_o,
  input logic [N_LVL+N_EDG-1:0] glitch_o
);
  for (genvar i = 0; i < N_LVL; i++) begin : g_l
    // R2: a qualified level needs the input low three edges back
    a_r2_level_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_mask_i && $rose(lvl_o[i])) |-> !$past(lvl_n_i[i], 3));
  end

  for (genvar j = 0; j < N_EDG; j++) begin : g_e
    // R4: a pulse follows an asserted sample
    a_r4_pulse_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edg_o[j] |-> !$past(edg_n_i[j], 3));
    // R5: pulses last one cycle
    a_r5_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edg_o[j] |=> !edg_o[j]);
  end

  for (genvar b = 0; b < N_LVL + N_EDG; b++) begin : g_f
    // R8: flags hold until cleared
    a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glitch_o[b] && !glitch_clr_i[b]) |=> glitch_o[b]);
  end

  // R9: masked input never raises its flag
  a_r9_mask_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(glitch_o[MASK_IDX]) |-> !$past(cfg_mask_i));
endmodule

bind async_input_qualifier aiq_checker #(
  .N_LVL    (N_LVL),
  .N_EDG    (N_EDG),
  .MASK_IDX (MASK_IDX)
) u_aiq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lvl_n_i      (lvl_n_i),
  .edg_n_i      (edg_n_i),
  .cfg_mask_i   (cfg_mask_i),
  .glitch_clr_i (glitch_clr_i),
  .lvl_o        (lvl_o),
  .edg_o        (edg_o),
  .glitch_o     (glitch_o)
);

// File: tb/async_input_qualifier_tb.sv
`timescale 1ns/1ps
module async_input_qualifier_tb;
  localparam int NL = 4;
  localparam int NE = 4;
  localparam int NG = NL + NE;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] lvl_n_i = '1;
  logic [NE-1:0] edg_n_i = '1;
  logic          cfg_mask_i = 1'b0;
  logic [NG-1:0] glitch_clr_i = '0;
  logic [NL-1:0] lvl_o;
  logic [NE-1:0] edg_o;
  logic [NG-1:0] glitch_o;

  int n_chk = 0;
  int n_err = 0;
  int pcount [NE];
  int wide_err = 0;
  logic [NE-1:0] prev_edg = '0;
  bit lvl1_seen = 1'b0;

  always #4 clk = ~clk;

  async_input_qualifier u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lvl_n_i(lvl_n_i), .edg_n_i(edg_n_i),
    .cfg_mask_i(cfg_mask_i), .glitch_clr_i(glitch_clr_i),
    .lvl_o(lvl_o), .edg_o(edg_o), .glitch_o(glitch_o)
  );

  initial for (int j = 0; j < NE; j++) pcount[j] = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      for (int j = 0; j < NE; j++) begin
        if (edg_o[j]) pcount[j]++;
        if (edg_o[j] && prev_edg[j]) wide_err++;
      end
      if (lvl_o[1]) lvl1_seen = 1'b1;
    end
    prev_edg = edg_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 lvl in reset", int'(lvl_o), 0);
    chk("R1 edg in reset", int'(edg_o), 0);
    chk("R1 flags in reset", int'(glitch_o), 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 idle after reset", int'({lvl_o, edg_o, glitch_o}), 0);
  endtask

  task automatic t_level_ok();
    lvl_n_i[0] = 1'b0;
    tick(3);
    chk("R2 level not yet", int'(lvl_o[0]), 0);
    tick(1);
    chk("R2 level qualified", int'(lvl_o[0]), 1);
    tick(4);
    chk("R2 level held", int'(lvl_o[0]), 1);
    lvl_n_i[0] = 1'b1;
    tick(2);
    chk("R2 level still high", int'(lvl_o[0]), 1);
    tick(1);
    chk("R2 level dropped", int'(lvl_o[0]), 0);
    chk("R2 no flag", int'(glitch_o[0]), 0);
  endtask

  task automatic t_level_short();
    lvl_n_i[1] = 1'b0;
    tick(1);
    lvl_n_i[1] = 1'b1;
    tick(6);
    chk("R3 short level ignored", int'(lvl1_seen), 0);
    chk("R3 short level flagged", int'(glitch_o[1]), 1);
  endtask

  task automatic t_clear();
    tick(5);
    chk("R8 flag sticky", int'(glitch_o[1]), 1);
    glitch_clr_i[1] = 1'b1;
    tick(1);
    glitch_clr_i[1] = 1'b0;
    chk("R8 flag cleared", int'(glitch_o[1]), 0);
    chk("R8 others untouched", int'(glitch_o), 0);
  endtask

  task automatic t_edge_ok();
    edg_n_i[0] = 1'b0;
    tick(3);
    chk("R4 pulse not yet", int'(edg_o[0]), 0);
    tick(1);
    chk("R4 pulse present", int'(edg_o[0]), 1);
    tick(1);
    chk("R5 pulse ends", int'(edg_o[0]), 0);
    tick(6);
    chk("R5 one pulse for long hold", pcount[0], 1);
    edg_n_i[0] = 1'b1;
    tick(2);
    // exactly MIN_LO negated samples then re-assert
    edg_n_i[0] = 1'b0;
    tick(6);
    chk("R4 re-armed after min gap", pcount[0], 2);
    edg_n_i[0] = 1'b1;
    tick(4);
    chk("R4 no flag on valid edges", int'(glitch_o[NL+0]), 0);
  endtask

  task automatic t_edge_too_soon();
    edg_n_i[1] = 1'b0;
    tick(5);
    edg_n_i[1] = 1'b1;
    tick(1);
    edg_n_i[1] = 1'b0;
    tick(6);
    edg_n_i[1] = 1'b1;
    tick(4);
    chk("R6 too-soon edge dropped", pcount[1], 1);
    chk("R6 too-soon edge flagged", int'(glitch_o[NL+1]), 1);
  endtask

  task automatic t_edge_short();
    edg_n_i[2] = 1'b0;
    tick(1);
    edg_n_i[2] = 1'b1;
    tick(6);
    chk("R7 short edge dropped", pcount[2], 0);
    chk("R7 short edge flagged", int'(glitch_o[NL+2]), 1);
    chk("R5 no wide pulses", wide_err, 0);
  endtask

  task automatic t_mask();
    glitch_clr_i = '1;
    tick(1);
    glitch_clr_i = '0;
    cfg_mask_i = 1'b1;
    tick(1);
    chk("R9 masked input reads satisfied", int'(lvl_o[3]), 1);
    chk("R9 other level unaffected", int'(lvl_o[0]), 0);
    lvl_n_i[3] = 1'b0;
    tick(1);
    lvl_n_i[3] = 1'b1;
    tick(6);
    chk("R9 masked input no flag", int'(glitch_o[3]), 0);
    chk("R9 masked still satisfied", int'(lvl_o[3]), 1);
    cfg_mask_i = 1'b0;
    tick(1);
    chk("R9 unmasked returns to input", int'(lvl_o[3]), 0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_level_ok();
    t_level_short();
    t_clear();
    t_edge_ok();
    t_edge_too_soon();
    t_edge_short();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule